// File: doc/BRIEF.md
# Pipeline Reset Flush Sequencer

This block wraps a small streaming arithmetic pipeline (an input register, a chain of constant-multiply stages and an accumulator) with a reset sequencer. Most flip-flops in the chain carry no reset at all. A one-cycle request on `rst_pulse` opens a flush window of a counted number of cycles instead. During that window the datapath input is forced to zero and marked invalid, so the unreset stage registers fill with known values. The only registers reset directly are the accumulator and the sequencer state, because they sit inside feedback loops.

While the window is open, `busy` is high, `data_out` reads zero, and any data offered on `data_in`/`data_valid` is dropped. Once `busy` falls, every interior stage holds a known value. The accumulator starts again from zero and sums the scaled samples accepted after the window. The window length comes from a parameter. It is never shorter than the input-to-accumulator latency, and a new request that arrives during a window restarts the count.

Top module: `stream_flush_pipe`

## Requirements
- R1: `rst_pulse` passes through one register before it is used. When it is sampled high on a rising edge, `busy` goes high after the next rising edge.
- R2: After each load of the window counter, `busy` stays high for exactly WINDOW consecutive cycles and then falls.
- R3: WINDOW equals FLUSH_CYCLES. If FLUSH_CYCLES is below the pipeline latency STAGES+1, WINDOW is raised to STAGES+1. With the defaults (STAGES=3, FLUSH_CYCLES=6), WINDOW is 6.
- R4: If `rst_pulse` is sampled high while `busy` is high, the counter reloads. `busy` then ends WINDOW cycles after the reload edge.
- R5: `data_out` is zero in every cycle in which `busy` is high.
- R6: On any rising edge where `busy` is high, `data_valid` and `data_in` are ignored. Samples offered then never appear in `data_out`.
- R7: An accepted sample is multiplied in turn by 3, 5, 7, … (stage i of STAGES, counted from 1, uses 2*i+1). Only the low DATA_W bits are kept after each multiply, and the result is zero-extended to ACC_W before it is added.
- R8: A sample accepted on rising edge k (`data_valid` high, `busy` low) is included in `data_out` after edge k+STAGES+1 and not before.
- R9: In the first cycle after `busy` falls, `data_out` is zero. From then on it equals the sum of the samples accepted after the window, whatever the stages held before.
- R10: A rising edge with `data_valid` low adds nothing to `data_out`, whatever value `data_in` has.
- R11: The accumulator wraps modulo 2^ACC_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_pulse | input | 1 | Single-cycle flush request, active high |
| data_in | input | DATA_W | Sample offered to the pipeline |
| data_valid | input | 1 | Qualifies `data_in` on the current edge |
| data_out | output | ACC_W | Accumulated result, forced to zero while busy |
| busy | output | 1 | High for the duration of the flush window |

## Verification
Two functions can collide in the same cycle. A flush request can land while scaled samples are still in the multiply stages, and a second request can reload a window that is still counting. The bench provokes both. It starts windows in the middle of a pseudo-random stream and issues a back-to-back request pair, then measures the whole `busy` run from the ports. A cycle-accurate reference model built from the timing rules judges every cycle. It drops in-flight samples at each window edge and requires `data_out` to be zero in the window and to follow the model from the first cycle after `busy` falls. It never looks at the unreset stages, so unknown values inside them are tolerated.

// File: rtl/flush_pkg.sv
package flush_pkg;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_FLUSH = 1'b1
    } seq_state_e;

    // Coefficient applied by multiply stage number idx (1-based).
    function automatic int unsigned stage_coef(input int unsigned idx);
        return 2 * idx + 1;
    endfunction

    // Flush window length: the request, but never below the pipe latency.
    function automatic int unsigned flush_window(input int unsigned req,
                                                 input int unsigned lat);
        return (req < lat) ? lat : req;
    endfunction

endpackage

// File: rtl/flush_ctrl.sv
module flush_ctrl
    import flush_pkg::*;
#(
    parameter int unsigned WINDOW = 6
) (
    input  logic clk,
    input  logic rst_pulse,
    output logic busy
);
    localparam int unsigned CW = $clog2(WINDOW + 1);

    logic              req_q;
    seq_state_e        state_q;
    logic [CW-1:0]     left_q;

    // Request is registered once; the registered copy acts as the
    // synchronous reset of the loop registers below.
    always_ff @(posedge clk) begin
        req_q <= rst_pulse;
    end

    always_ff @(posedge clk) begin
        if (req_q) begin
            state_q <= SEQ_FLUSH;
            left_q  <= CW'(WINDOW - 1);
        end else if (state_q == SEQ_FLUSH) begin
            if (left_q == '0) begin
                state_q <= SEQ_IDLE;
            end else begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    assign busy = (state_q == SEQ_FLUSH);

endmodule

// File: rtl/flush_stage.sv
module flush_stage #(
    parameter int unsigned DW   = 16,
    parameter int unsigned COEF = 1
) (
    input  logic          clk,
    input  logic          in_vld,
    input  logic [DW-1:0] in_val,
    output logic          out_vld,
    output logic [DW-1:0] out_val
);
    // Feed-forward register: deliberately no reset, flushed by zeros.
    always_ff @(posedge clk) begin
        out_vld <= in_vld;
    end

    if (COEF == 1) begin : g_pass
        always_ff @(posedge clk) begin
            out_val <= in_val;
        end
    end else begin : g_scale
        localparam logic [DW-1:0] K = DW'(COEF);
        always_ff @(posedge clk) begin
            out_val <= in_val * K;
        end
    end

endmodule

// File: rtl/flush_acc.sv
module flush_acc #(
    parameter int unsigned DW = 16,
    parameter int unsigned AW = 24
) (
    input  logic          clk,
    input  logic          clear,
    input  logic          in_vld,
    input  logic [DW-1:0] in_val,
    output logic [AW-1:0] sum_out
);
    logic [AW-1:0] acc_q;

    // Feedback register: cleared directly on every window cycle.
    always_ff @(posedge clk) begin
        if (clear) begin
            acc_q <= '0;
        end else if (in_vld) begin
            acc_q <= acc_q + AW'(in_val);
        end
    end

    assign sum_out = clear ? '0 : acc_q;

endmodule

// File: rtl/stream_flush_pipe.sv
module stream_flush_pipe
    import flush_pkg::*;
#(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned ACC_W        = 24,
    parameter int unsigned STAGES       = 3,
    parameter int unsigned FLUSH_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_pulse,
    input  logic [DATA_W-1:0] data_in,
    input  logic              data_valid,
    output logic [ACC_W-1:0]  data_out,
    output logic              busy
);
    localparam int unsigned LAT    = STAGES + 1;
    localparam int unsigned WINDOW = flush_window(FLUSH_CYCLES, LAT);
    localparam int unsigned NPOS   = STAGES + 2;

    logic [DATA_W-1:0] pv  [NPOS];
    logic              pvl [NPOS];

    flush_ctrl #(.WINDOW(WINDOW)) u_ctrl (
        .clk       (clk),
        .rst_pulse (rst_pulse),
        .busy      (busy)
    );

    // Input gate: zeros and no valid while the window is open.
    assign pv[0]  = busy ? '0 : data_in;
    assign pvl[0] = data_valid & ~busy;

    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
        flush_stage #(
            .DW   (DATA_W),
            .COEF ((g == 0) ? 1 : stage_coef(g))
        ) u_stage (
            .clk     (clk),
            .in_vld  (pvl[g]),
            .in_val  (pv[g]),
            .out_vld (pvl[g+1]),
            .out_val (pv[g+1])
        );
    end

    flush_acc #(.DW(DATA_W), .AW(ACC_W)) u_acc (
        .clk     (clk),
        .clear   (busy),
        .in_vld  (pvl[NPOS-1]),
        .in_val  (pv[NPOS-1]),
        .sum_out (data_out)
    );

endmodule

// File: rtl/stream_flush_pipe_chk.sv
module stream_flush_pipe_chk #(
    parameter int unsigned WINDOW = 6,
    parameter int unsigned ACC_W  = 24
) (
    input logic             clk,
    input logic             rst_pulse,
    input logic             busy,
    input logic [ACC_W-1:0] data_out
);
    localparam int unsigned CW = $clog2(WINDOW + 1);

    logic          live  = 1'b0;
    logic          rq_c  = 1'b0;
    logic [CW-1:0] rem_c = '0;

    // Independent window tracker, armed by the first registered request.
    always_ff @(posedge clk) begin
        rq_c <= rst_pulse;
        if (rq_c) live <= 1'b1;
        if (rq_c) begin
            rem_c <= CW'(WINDOW);
        end else if (rem_c != '0) begin
            rem_c <= rem_c - 1'b1;
        end
    end

    // R1
    a_r1_pulse_to_busy: assert property (@(posedge clk) disable iff (!live)
        rst_pulse |-> ##2 busy);

    // R2 and R4
    a_r2_r4_window_len: assert property (@(posedge clk) disable iff (!live)
        busy == (rem_c != '0));

    // R5
    a_r5_out_quiet: assert property (@(posedge clk) disable iff (!live)
        (busy && $past(busy)) |-> $stable(data_out));

    // R9
    a_r9_clear_after: assert property (@(posedge clk) disable iff (!live)
        $fell(busy) |-> (data_out == '0));

endmodule

bind stream_flush_pipe stream_flush_pipe_chk #(
    .WINDOW (WINDOW),
    .ACC_W  (ACC_W)
) u_chk (
    .clk       (clk),
    .rst_pulse (rst_pulse),
    .busy      (busy),
    .data_out  (data_out)
);

// File: tb/stream_flush_pipe_tb.sv
module stream_flush_pipe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW    = 16;
    localparam int AW    = 24;
    localparam int STG   = 3;
    localparam int FLUSH = 6;
    localparam int LAT   = STG + 1;
    localparam int WIN   = (FLUSH < LAT) ? LAT : FLUSH;

    logic          clk = 1'b0;
    logic          rst_pulse;
    logic [DW-1:0] data_in;
    logic          data_valid;
    logic [AW-1:0] data_out;
    logic          busy;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_flush_pipe #(.DATA_W(DW), .ACC_W(AW), .STAGES(STG),
                        .FLUSH_CYCLES(FLUSH)) u_dut (
        .clk(clk), .rst_pulse(rst_pulse), .data_in(data_in),
        .data_valid(data_valid), .data_out(data_out), .busy(busy));

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R7 reference: successive multiplies by 3,5,7,... truncated to DW.
    function automatic logic [DW-1:0] scaled(input logic [DW-1:0] x);
        logic [DW-1:0] v = x;
        for (int i = 1; i <= STG; i++) begin
            logic [31:0] t = v * (2 * i + 1);
            v = t[DW-1:0];
        end
        return v;
    endfunction

    // Scoreboard: accepted samples queue with the edge they are due on.
    typedef struct { int unsigned due; logic [AW-1:0] val; } item_t;
    item_t q[$];

    int unsigned   e_n   = 0;
    int unsigned   m_rem = 0;
    bit            m_rq  = 0;
    logic [AW-1:0] m_acc = '0;
    bit            armed = 0;

    // Monitor: replays the edge just passed, then compares the ports.
    always @(negedge clk) begin
        bit pre;
        e_n++;
        pre = (m_rem != 0);
        if (pre) begin
            m_acc = '0;
            q.delete();
        end else begin
            while (q.size() > 0 && q[0].due == e_n) begin
                m_acc = m_acc + q[0].val;
                void'(q.pop_front());
            end
        end
        if (data_valid === 1'b1 && !pre)
            q.push_back('{due: e_n + LAT, val: AW'(scaled(data_in))});
        if (m_rq) m_rem = WIN;
        else if (m_rem != 0) m_rem--;
        m_rq = rst_pulse;
        if (m_rem != 0) armed = 1;
        if (armed && !done) begin
            check(busy === (m_rem != 0), "R2/R4 busy", 32'(busy), 32'(m_rem != 0));
            if (m_rem != 0)
                check(data_out === '0, "R5 data_out in window", 32'(data_out), 0);
            else
                check(data_out === m_acc, "R8/R9 data_out vs model",
                      32'(data_out), 32'(m_acc));
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_and_wait();
        rst_pulse = 1'b1;
        tick();
        rst_pulse = 1'b0;
        for (int i = 0; i < 4 * WIN + 8 && (busy !== 1'b0 || i < 2); i++) tick();
    endtask

    initial begin
        int len;
        logic [15:0] lfsr;
        longint unsigned big;
        rst_pulse  = 1'b1;
        data_valid = 1'b0;
        data_in    = '0;
        tick();
        rst_pulse = 1'b0;
        repeat (WIN + 2) tick();
        check(busy === 1'b0, "R2 reset state busy", 32'(busy), 0);
        check(data_out === '0, "R9 reset state data_out", 32'(data_out), 0);

        // R1, R2, R3: delay and length of one window
        rst_pulse = 1'b1;
        tick();
        rst_pulse = 1'b0;
        check(busy === 1'b0, "R1 busy one cycle after request", 32'(busy), 0);
        tick();
        check(busy === 1'b1, "R1 busy two cycles after request", 32'(busy), 1);
        len = 1;
        for (int i = 0; i < 50 && busy === 1'b1; i++) begin
            tick();
            if (busy === 1'b1) len++;
        end
        check(len == WIN, "R3 window length", 32'(len), 32'(WIN));

        // R7, R8: single sample latency and scaling
        data_in = 16'd5; data_valid = 1'b1;
        tick();
        data_valid = 1'b0;
        repeat (LAT - 1) tick();
        check(data_out === '0, "R8 sample not early", 32'(data_out), 0);
        tick();
        check(data_out === 24'd525, "R7 scaled sample", 32'(data_out), 525);

        // R10: invalid samples add nothing
        data_in = 16'h1234;
        repeat (10) tick();
        check(data_out === 24'd525, "R10 invalid ignored", 32'(data_out), 525);

        // R6: samples offered during a window are dropped
        rst_pulse = 1'b1;
        tick();
        rst_pulse = 1'b0;
        tick();
        data_in = 16'h7777; data_valid = 1'b1;
        for (int i = 0; i < 50 && busy === 1'b1; i++) begin
            tick();
            if (busy !== 1'b1) data_valid = 1'b0;
        end
        data_valid = 1'b0;
        for (int i = 0; i < LAT + 2; i++) begin
            check(data_out === '0, "R6 window samples dropped", 32'(data_out), 0);
            tick();
        end

        // R4: reload during a window
        rst_pulse = 1'b1;
        tick();
        rst_pulse = 1'b0;
        tick();
        rst_pulse = 1'b1;
        tick();
        rst_pulse = 1'b0;
        len = 2;
        for (int i = 0; i < 50 && busy === 1'b1; i++) begin
            tick();
            if (busy === 1'b1) len++;
        end
        check(len == WIN + 2, "R4 reload extends window", 32'(len), 32'(WIN + 2));

        // Pseudo-random stream with windows opened mid-flight
        lfsr = 16'hACE1;
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            data_in    = lfsr;
            data_valid = lfsr[3] | lfsr[7];
            rst_pulse  = (i == 100) || (i == 104) || (i == 211);
            tick();
        end
        rst_pulse = 1'b0;
        data_valid = 1'b0;
        repeat (WIN + LAT + 2) tick();

        // R11: accumulator wrap
        pulse_and_wait();
        data_in = 16'hFFFF; data_valid = 1'b1;
        repeat (300) tick();
        data_valid = 1'b0;
        repeat (LAT + 1) tick();
        big = 64'd300 * 64'(scaled(16'hFFFF));
        check(big > (64'd1 << AW), "R11 sum exceeds range", 32'(big >> AW), 1);
        check(data_out === AW'(big), "R11 wrapped sum", 32'(data_out), 32'(AW'(big)));

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule